// File: doc/BRIEF.md
# LIN Node Operating-Mode Controller

This block is the digital mode controller of a LIN physical-layer node. It watches three asynchronous control pins from the host microcontroller (enable, standby request and transmit data), a wake-event pulse from the wake detectors, and three supply-monitor flags. From these it selects one of five operating modes: power-off, stand-by, normal slope, low slope and sleep. For each mode it drives the enables of the analog circuits that surround it: the core-supply regulator, the bus transmitter, the bus termination choice, the inhibit output and the receive-pin behaviour.

The three control pins pass through two-flop synchronizers. The flags and the wake pulse are taken as already synchronous to the clock. The slope mode is picked by the transmit-data level seen in the same synchronized cycle as the enable rising edge. A low-slope entry keeps the transmitter silent until transmit data has been seen recessive. The inhibit output is raised only when the standby pin was high at the moment a normal mode was entered. The current mode is exported as a 3-bit code, and a one-cycle pulse flags every mode change.

Top module: `lin_mode_ctrl`

## Requirements
- R1: While the battery is below its power-on-reset level (`bat_por_low`=1), and after reset, the mode code is 0 (power-off), and `reg_en_o`, `tx_en_o`, `term_res_o` and `inh_drv_o` are 0 with `rxd_sel_o`=2 (clamped). Once `bat_por_low` and `bat_uv` are both 0, the next clock moves the mode to stand-by (code 1).
- R2: In stand-by, `reg_en_o`=1, `tx_en_o`=0, `term_res_o`=0 (current source only), `inh_drv_o`=0 and `rxd_sel_o`=0 (pulled high). `tx_en_o` is never 1 unless `term_res_o` and `reg_en_o` are both 1.
- R3: A synchronized rising edge of `en_pin` in stand-by, with `txd_pin` high in that cycle, enters normal slope (code 2) with `tx_en_o`=1, `term_res_o`=1 (resistor) and `rxd_sel_o`=1 (bus data).
- R4: The same edge with `txd_pin` low enters low slope (code 3). `tx_en_o` stays 0 until `txd_pin` has been seen high, then stays 1 for the rest of the mode, even if `txd_pin` goes low again.
- R5: Entry into either normal mode is refused while `vcc_uv` or `bat_uv` is 1 at the enable edge; the mode stays stand-by.
- R6: `inh_drv_o` becomes 1 on entry into a normal mode only if `stb_pin` is high in the entry cycle. It holds that value while the mode lasts and returns to 0 on leaving it.
- R7: A synchronized falling edge of `en_pin` in either normal mode goes to stand-by if `stb_pin` is high or `bat_uv` is 1. Otherwise it goes to sleep (code 4). Sleep is entered from no other mode.
- R8: In sleep, `reg_en_o`, `tx_en_o`, `term_res_o` and `inh_drv_o` are 0 and `rxd_sel_o`=2. Enable edges are ignored. A `wake_evt` pulse moves the mode to stand-by on the next clock.
- R9: `bat_por_low`=1 forces power-off on the next clock from any mode.
- R10: While `bat_uv` is 1, `tx_en_o` is 0 in the same cycle, whatever the mode. The mode itself does not change.
- R11: `mode_o` carries the codes off=0, stand-by=1, normal slope=2, low slope=3 and sleep=4. `mode_chg_o` is 1 for exactly the first cycle in which `mode_o` shows a new value.
- R12: A change on `en_pin`, `stb_pin` or `txd_pin`, applied between clock edges, acts on the mode at the third rising edge that follows. No earlier edge reacts to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_pin | input | 1 | Host enable pin, asynchronous |
| stb_pin | input | 1 | Host standby-request pin, asynchronous |
| txd_pin | input | 1 | Transmit data pin, low = dominant, asynchronous |
| wake_evt | input | 1 | One-cycle local or bus wake-up event |
| bat_por_low | input | 1 | Battery below power-on-reset level |
| bat_uv | input | 1 | Battery below undervoltage threshold |
| vcc_uv | input | 1 | Core supply below undervoltage threshold |
| reg_en_o | output | 1 | Core-supply regulator enable |
| tx_en_o | output | 1 | Bus transmitter enable |
| term_res_o | output | 1 | 1 = resistor termination, 0 = current-source pull-up |
| inh_drv_o | output | 1 | Drive inhibit output high (0 = floating) |
| rxd_sel_o | output | 2 | Receive pin: 0 pulled high, 1 bus data, 2 clamped |
| mode_o | output | 3 | Current mode code |
| mode_chg_o | output | 1 | One-cycle pulse on every mode change |

## Verification
A wrong mode register shows at once on `mode_o` and on the enable bundle. The bench compares the whole bundle in the first sample after each transition, so an early or late move is caught as an off-by-one-cycle mismatch. A wrong low-slope arming flag or inhibit latch does not change the mode code and shows only on `tx_en_o` or `inh_drv_o`. These are checked both at entry and after the transmit pin toggles later in the mode. Synchronizer depth errors appear as a transition one edge early or late, and the bench samples both the edge before and the edge of the expected change.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;

    typedef enum logic [2:0] {
        MODE_OFF   = 3'd0,
        MODE_STBY  = 3'd1,
        MODE_NORM  = 3'd2,
        MODE_LOW   = 3'd3,
        MODE_SLEEP = 3'd4
    } mode_e;

    typedef enum logic [1:0] {
        RX_PULLUP = 2'd0,
        RX_BUS    = 2'd1,
        RX_CLAMP  = 2'd2
    } rxsel_e;

    typedef struct packed {
        mode_e mode;
        logic  inh;
        logic  armed;
        logic  en_prev;
        logic  chg;
    } fsm_state_t;

endpackage

// File: rtl/lin_pin_sync.sv
module lin_pin_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            logic [WIDTH-1:0] stage_d;
            if (s == 0) begin : g_first
                assign stage_d = async_i;
            end else begin : g_rest
                assign stage_d = stage_q[s-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= stage_d;
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/lin_mode_fsm.sv
module lin_mode_fsm
    import lin_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_s,
    input  logic       stb_s,
    input  logic       txd_s,
    input  logic       wake_evt,
    input  logic       bat_por_low,
    input  logic       bat_uv,
    input  logic       vcc_uv,
    output fsm_state_t state_o
);
    fsm_state_t state_d, state_q;
    logic en_rise, en_fall;

    always_comb begin
        state_d         = state_q;
        en_rise         = en_s & ~state_q.en_prev;
        en_fall         = ~en_s & state_q.en_prev;
        state_d.en_prev = en_s;
        unique case (state_q.mode)
            MODE_OFF: begin
                if (!bat_uv) state_d.mode = MODE_STBY;
            end
            MODE_STBY: begin
                if (en_rise && !vcc_uv && !bat_uv) begin
                    state_d.mode  = txd_s ? MODE_NORM : MODE_LOW;
                    state_d.inh   = stb_s;
                    state_d.armed = txd_s;
                end
            end
            MODE_NORM, MODE_LOW: begin
                if (state_q.mode == MODE_LOW && txd_s) state_d.armed = 1'b1;
                if (en_fall) begin
                    state_d.mode  = (stb_s || bat_uv) ? MODE_STBY : MODE_SLEEP;
                    state_d.inh   = 1'b0;
                    state_d.armed = 1'b0;
                end
            end
            MODE_SLEEP: begin
                if (wake_evt) state_d.mode = MODE_STBY;
            end
            default: begin
                state_d.mode = MODE_OFF;
            end
        endcase
        if (bat_por_low) begin
            state_d.mode  = MODE_OFF;
            state_d.inh   = 1'b0;
            state_d.armed = 1'b0;
        end
        state_d.chg = (state_d.mode != state_q.mode);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.mode    <= MODE_OFF;
            state_q.inh     <= 1'b0;
            state_q.armed   <= 1'b0;
            state_q.en_prev <= 1'b0;
            state_q.chg     <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign state_o = state_q;

    // R9
    por_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bat_por_low |=> state_q.mode == MODE_OFF);

    // R5
    entry_supply_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q.mode == MODE_NORM || state_q.mode == MODE_LOW) && $past(state_q.mode) == MODE_STBY)
        |-> ($past(vcc_uv) == 1'b0 && $past(bat_uv) == 1'b0));

    // R4
    low_entry_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.mode == MODE_LOW && $past(state_q.mode) == MODE_STBY) |-> !state_q.armed);

    // R7
    sleep_from_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.mode == MODE_SLEEP && $past(state_q.mode) != MODE_SLEEP)
        |-> ($past(state_q.mode) == MODE_NORM || $past(state_q.mode) == MODE_LOW));

    // R11
    mode_chg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.chg |-> state_q.mode != $past(state_q.mode));
endmodule

// File: rtl/lin_mode_decode.sv
module lin_mode_decode
    import lin_mode_pkg::*;
(
    input  mode_e       mode_i,
    input  logic        armed_i,
    input  logic        inh_i,
    input  logic        bat_uv,
    output logic        reg_en_o,
    output logic        tx_en_o,
    output logic        term_res_o,
    output logic        inh_drv_o,
    output logic [1:0]  rxd_sel_o
);
    rxsel_e rx_sel;

    always_comb begin
        reg_en_o   = 1'b0;
        tx_en_o    = 1'b0;
        term_res_o = 1'b0;
        inh_drv_o  = 1'b0;
        rx_sel     = RX_CLAMP;
        unique case (mode_i)
            MODE_STBY: begin
                reg_en_o = 1'b1;
                rx_sel   = RX_PULLUP;
            end
            MODE_NORM: begin
                reg_en_o   = 1'b1;
                tx_en_o    = ~bat_uv;
                term_res_o = 1'b1;
                inh_drv_o  = inh_i;
                rx_sel     = RX_BUS;
            end
            MODE_LOW: begin
                reg_en_o   = 1'b1;
                tx_en_o    = armed_i & ~bat_uv;
                term_res_o = 1'b1;
                inh_drv_o  = inh_i;
                rx_sel     = RX_BUS;
            end
            default: begin
                rx_sel = RX_CLAMP;
            end
        endcase
    end

    assign rxd_sel_o = rx_sel;
endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl
    import lin_mode_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_pin,
    input  logic       stb_pin,
    input  logic       txd_pin,
    input  logic       wake_evt,
    input  logic       bat_por_low,
    input  logic       bat_uv,
    input  logic       vcc_uv,
    output logic       reg_en_o,
    output logic       tx_en_o,
    output logic       term_res_o,
    output logic       inh_drv_o,
    output logic [1:0] rxd_sel_o,
    output logic [2:0] mode_o,
    output logic       mode_chg_o
);
    localparam int NPINS = 3;
    localparam logic [NPINS-1:0] PIN_RST = 3'b100;

    logic [NPINS-1:0] pins_s;
    fsm_state_t       st;

    lin_pin_sync #(
        .WIDTH  (NPINS),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PIN_RST)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({txd_pin, stb_pin, en_pin}),
        .sync_o (pins_s)
    );

    lin_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_s       (pins_s[0]),
        .stb_s      (pins_s[1]),
        .txd_s      (pins_s[2]),
        .wake_evt   (wake_evt),
        .bat_por_low(bat_por_low),
        .bat_uv     (bat_uv),
        .vcc_uv     (vcc_uv),
        .state_o    (st)
    );

    lin_mode_decode u_dec (
        .mode_i    (st.mode),
        .armed_i   (st.armed),
        .inh_i     (st.inh),
        .bat_uv    (bat_uv),
        .reg_en_o  (reg_en_o),
        .tx_en_o   (tx_en_o),
        .term_res_o(term_res_o),
        .inh_drv_o (inh_drv_o),
        .rxd_sel_o (rxd_sel_o)
    );

    assign mode_o     = st.mode;
    assign mode_chg_o = st.chg;

    // R10
    uv_tx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bat_uv |-> !tx_en_o);

    // R2
    tx_needs_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en_o |-> (term_res_o && reg_en_o));
endmodule

// File: tb/tb_lin_mode_ctrl.sv
module tb_lin_mode_ctrl;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n, en_pin, stb_pin, txd_pin, wake_evt, bat_por_low, bat_uv, vcc_uv;
    logic reg_en_o, tx_en_o, term_res_o, inh_drv_o, mode_chg_o;
    logic [1:0] rxd_sel_o;
    logic [2:0] mode_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lin_mode_ctrl dut (
        .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .stb_pin(stb_pin), .txd_pin(txd_pin),
        .wake_evt(wake_evt), .bat_por_low(bat_por_low), .bat_uv(bat_uv), .vcc_uv(vcc_uv),
        .reg_en_o(reg_en_o), .tx_en_o(tx_en_o), .term_res_o(term_res_o), .inh_drv_o(inh_drv_o),
        .rxd_sel_o(rxd_sel_o), .mode_o(mode_o), .mode_chg_o(mode_chg_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // bundle = {mode[2:0], reg, tx, term, inh, rxd[1:0]}
    task automatic chk_outs(input string req, input logic [2:0] m, input logic r, input logic t,
                            input logic tr, input logic ih, input logic [1:0] rx);
        chk(req, {7'd0, mode_o, reg_en_o, tx_en_o, term_res_o, inh_drv_o, rxd_sel_o},
                 {7'd0, m, r, t, tr, ih, rx});
    endtask

    task automatic wait_pins();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; en_pin = 1'b0; stb_pin = 1'b0; txd_pin = 1'b1; wake_evt = 1'b0;
        bat_por_low = 1'b1; bat_uv = 1'b1; vcc_uv = 1'b1;
        repeat (3) @(negedge clk);
        chk_outs("R1 reset", 3'd0, 0, 0, 0, 0, 2'd2);
        rst_n = 1'b1;
    endtask

    task automatic t_powerup();
        @(negedge clk);
        bat_por_low = 1'b0;
        @(posedge clk); @(negedge clk);
        chk_outs("R1 off while battery low", 3'd0, 0, 0, 0, 0, 2'd2);
        bat_uv = 1'b0; vcc_uv = 1'b0;
        @(posedge clk); @(negedge clk);
        chk_outs("R2 standby after power-up", 3'd1, 1, 0, 0, 0, 2'd0);
        chk("R11 change pulse", {15'd0, mode_chg_o}, 16'd1);
        @(posedge clk); @(negedge clk);
        chk("R11 pulse one cycle", {15'd0, mode_chg_o}, 16'd0);
    endtask

    task automatic t_blocked();
        vcc_uv = 1'b1; txd_pin = 1'b1; en_pin = 1'b1;
        wait_pins();
        repeat (2) @(negedge clk);
        chk("R5 entry refused on core undervoltage", {13'd0, mode_o}, 16'd1);
        en_pin = 1'b0;
        wait_pins();
        vcc_uv = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_normal();
        stb_pin = 1'b1; txd_pin = 1'b1; en_pin = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R12 no action before third edge", {13'd0, mode_o}, 16'd1);
        @(posedge clk); @(negedge clk);
        chk_outs("R3 normal slope entry, R6 INH high", 3'd2, 1, 1, 1, 1, 2'd1);
        chk("R11 pulse on normal entry", {15'd0, mode_chg_o}, 16'd1);
        bat_uv = 1'b1;
        #1;
        chk("R10 undervoltage kills transmitter", {15'd0, tx_en_o}, 16'd0);
        @(negedge clk);
        chk("R10 mode kept under undervoltage", {13'd0, mode_o}, 16'd2);
        bat_uv = 1'b0;
        stb_pin = 1'b0;
        wait_pins();
        chk("R6 INH held after STB drops", {15'd0, inh_drv_o}, 16'd1);
        stb_pin = 1'b1;
        en_pin = 1'b0;
        wait_pins();
        chk_outs("R7 EN fall with STB high to standby", 3'd1, 1, 0, 0, 0, 2'd0);
    endtask

    task automatic t_low_sleep();
        stb_pin = 1'b0; txd_pin = 1'b0; en_pin = 1'b1;
        wait_pins();
        chk_outs("R4 low slope entry silent, R6 INH floats", 3'd3, 1, 0, 1, 0, 2'd1);
        repeat (5) @(negedge clk);
        chk("R4 still silent while TxD low", {15'd0, tx_en_o}, 16'd0);
        txd_pin = 1'b1;
        wait_pins();
        chk("R4 transmitter on after TxD high", {15'd0, tx_en_o}, 16'd1);
        txd_pin = 1'b0;
        wait_pins();
        chk("R4 stays on after TxD low again", {15'd0, tx_en_o}, 16'd1);
        txd_pin = 1'b1;
        en_pin = 1'b0;
        wait_pins();
        chk_outs("R7 EN fall with STB low to sleep, R8 outputs", 3'd4, 0, 0, 0, 0, 2'd2);
        en_pin = 1'b1;
        wait_pins();
        @(negedge clk);
        chk("R8 EN edge ignored in sleep", {13'd0, mode_o}, 16'd4);
        en_pin = 1'b0;
        wait_pins();
        wake_evt = 1'b1;
        @(negedge clk);
        wake_evt = 1'b0;
        chk_outs("R8 wake to standby", 3'd1, 1, 0, 0, 0, 2'd0);
    endtask

    task automatic t_uv_exit_and_por();
        stb_pin = 1'b0; txd_pin = 1'b1; en_pin = 1'b1;
        wait_pins();
        chk("R3 re-entry normal", {13'd0, mode_o}, 16'd2);
        bat_uv = 1'b1;
        en_pin = 1'b0;
        wait_pins();
        chk("R7 EN fall under battery UV to standby", {13'd0, mode_o}, 16'd1);
        bat_uv = 1'b0;
        en_pin = 1'b1;
        wait_pins();
        chk("R3 entry before reset test", {13'd0, mode_o}, 16'd2);
        bat_por_low = 1'b1;
        @(negedge clk);
        chk_outs("R9 forced power-off", 3'd0, 0, 0, 0, 0, 2'd2);
        bat_por_low = 1'b0;
        @(negedge clk);
        chk("R1 back to standby", {13'd0, mode_o}, 16'd1);
    endtask

    initial begin
        t_reset();
        t_powerup();
        t_blocked();
        t_normal();
        t_low_sleep();
        t_uv_exit_and_por();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule